// File: doc/BRIEF.md
# Auto-Reload Duty-Compare PWM Generator

This block produces a pulse-width-modulated level from a free-running up-counter. A new cycle starts with the counter at a programmable start value. It counts up by one on every clock and ends when it wraps from its all-ones value. The width of the period therefore comes from how far the start value sits below the wrap point, not from a terminal-count compare. The high portion of each cycle comes first. The output falls when the counter reaches the duty compare value and rises again at the start of the next cycle.

Both the start value and the duty value are sampled only when a cycle begins. Software may rewrite either input at any time without disturbing the cycle in progress. A one-clock strobe marks every wrap, so a controller can pace its updates to the cycle. A separate output enable gates the pin while the counter keeps running.

Top module: `pwm_ar_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, with the timer enable low, `pwm_out` and `cycle_end` are 0.
- R2: When `tmr_en` rises, the counter loads `reload_val` on that clock edge and `duty_val` is captured. If the two differ and `pwm_en` is 1, `pwm_out` is 1 in the following cycle.
- R3: While enabled, cycles follow each other back to back, and each lasts 2^WIDTH − `reload_val` clocks. For WIDTH = 8 that is 256 − reload, so a reload of 0xFF gives one-clock cycles.
- R4: When the captured duty value is at least the captured start value, `pwm_out` is high for exactly duty − reload clocks at the start of each cycle and low for the rest. A duty equal to the start value gives a cycle that is low throughout.
- R5: When the captured duty value is below the captured start value, no match occurs and `pwm_out` stays high for the whole cycle.
- R6: `cycle_end` is high for exactly one clock per wrap, in the first clock of the new cycle. At that point the counter holds the start value sampled at the wrap edge.
- R7: With `pwm_en` at 0, `pwm_out` is 0 one clock later, while the counter and `cycle_end` keep running.
- R8: With `tmr_en` at 0, `pwm_out` and `cycle_end` are 0 from the next clock on.
- R9: A change of `reload_val` during a cycle does not alter that cycle's length. It takes effect from the next wrap.
- R10: A change of `duty_val` during a cycle does not alter that cycle's high time. The captured copy changes only at a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Counter run enable; a rising level starts a fresh cycle |
| pwm_en | input | 1 | Gates the PWM level onto `pwm_out` |
| reload_val | input | WIDTH | Counter start value, sampled at each load |
| duty_val | input | WIDTH | Count at which the output falls, sampled at each load |
| pwm_out | output | 1 | Registered PWM level |
| cycle_end | output | 1 | One-clock strobe on each wrap from all-ones |

## Verification
The assertions assume that `reload_val` and `duty_val` are sampled only on the edges where the block loads. They also assume that the counter advances by one on every enabled clock that is not a wrap, so the start of each cycle is defined by the counter's own history. The bench changes the two value inputs only on falling clock edges, either while the timer is stopped or right after a `cycle_end` strobe. That keeps each load edge seeing one settled value. It also means every measured cycle has a known captured pair, so the expected period and high time follow directly from the requirements.

// File: rtl/pwm_ar_pkg.sv
package pwm_ar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/pwm_ar_counter.sv
module pwm_ar_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic [WIDTH-1:0] reload_val,
  input  logic [WIDTH-1:0] duty_val,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cnt_n,
  output logic [WIDTH-1:0] duty_q,
  output logic [WIDTH-1:0] duty_n,
  output logic             run_q,
  output logic             load_n,
  output logic             wrap_n
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic start_n;

  always_comb begin
    start_n = tmr_en && !run_q;
    wrap_n  = tmr_en && run_q && (cnt_q == CNT_MAX);
    load_n  = start_n || wrap_n;
    if (!tmr_en)
      cnt_n = cnt_q;
    else if (load_n)
      cnt_n = reload_val;
    else
      cnt_n = cnt_q + CNT_ONE;
    duty_n = load_n ? duty_val : duty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      duty_q <= duty_n;
      run_q  <= tmr_en;
    end
  end
endmodule

// File: rtl/pwm_ar_phase.sv
module pwm_ar_phase
  import pwm_ar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic             load_n,
  input  logic [WIDTH-1:0] cnt_n,
  input  logic [WIDTH-1:0] duty_n,
  output phase_e           phase_q,
  output phase_e           phase_n
);
  logic match_n;

  always_comb begin
    match_n = (cnt_n == duty_n);
    if (!tmr_en)
      phase_n = PH_IDLE;
    else if (load_n)
      phase_n = match_n ? PH_LOW : PH_HIGH;
    else if (phase_q == PH_HIGH && match_n)
      phase_n = PH_LOW;
    else
      phase_n = phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= PH_IDLE;
    else
      phase_q <= phase_n;
  end
endmodule

// File: rtl/pwm_ar_outstage.sv
module pwm_ar_outstage
  import pwm_ar_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pwm_en,
  input  phase_e phase_n,
  input  logic   wrap_n,
  output logic   pwm_out,
  output logic   cycle_end
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out   <= 1'b0;
      cycle_end <= 1'b0;
    end else begin
      pwm_out   <= pwm_en && (phase_n == PH_HIGH);
      cycle_end <= wrap_n;
    end
  end
endmodule

// File: rtl/pwm_ar_gen.sv
module pwm_ar_gen
  import pwm_ar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic             pwm_en,
  input  logic [WIDTH-1:0] reload_val,
  input  logic [WIDTH-1:0] duty_val,
  output logic             pwm_out,
  output logic             cycle_end
);
  logic [WIDTH-1:0] cnt_q, cnt_n, duty_q, duty_n;
  logic             run_q, load_n, wrap_n;
  phase_e           phase_q, phase_n;

  pwm_ar_counter #(.WIDTH(WIDTH)) u_counter (
    .clk(clk), .rst(rst), .tmr_en(tmr_en),
    .reload_val(reload_val), .duty_val(duty_val),
    .cnt_q(cnt_q), .cnt_n(cnt_n), .duty_q(duty_q), .duty_n(duty_n),
    .run_q(run_q), .load_n(load_n), .wrap_n(wrap_n)
  );

  pwm_ar_phase #(.WIDTH(WIDTH)) u_phase (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .load_n(load_n),
    .cnt_n(cnt_n), .duty_n(duty_n),
    .phase_q(phase_q), .phase_n(phase_n)
  );

  pwm_ar_outstage u_out (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .phase_n(phase_n),
    .wrap_n(wrap_n), .pwm_out(pwm_out), .cycle_end(cycle_end)
  );
endmodule

// File: rtl/pwm_ar_chk.sv
module pwm_ar_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tmr_en,
  input logic             pwm_en,
  input logic [WIDTH-1:0] reload_val,
  input logic [WIDTH-1:0] duty_val,
  input logic             pwm_out,
  input logic             cycle_end,
  input logic [WIDTH-1:0] cnt_q,
  input logic [WIDTH-1:0] duty_q,
  input logic             run_q
);
  // R8
  timer_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> (!pwm_out && !cycle_end));

  // R7
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_out);

  // R6
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> (cnt_q == $past(reload_val)));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (cnt_q == $past(reload_val) && duty_q == $past(duty_val)));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run_q) && $past(tmr_en) && !cycle_end) |->
      (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

  // R10
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run_q) && run_q && !cycle_end) |-> $stable(duty_q));
endmodule

bind pwm_ar_gen pwm_ar_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .tmr_en(tmr_en), .pwm_en(pwm_en),
  .reload_val(reload_val), .duty_val(duty_val),
  .pwm_out(pwm_out), .cycle_end(cycle_end),
  .cnt_q(cnt_q), .duty_q(duty_q), .run_q(run_q)
);

// File: tb/pwm_ar_gen_tb.sv
module pwm_ar_gen_tb;
  localparam int W = 8;
  localparam int NV = 8;
  // reload, duty, expected period, expected high clocks
  localparam int VEC [NV][4] = '{
    '{8'h00, 8'h80, 256, 128},
    '{8'hF0, 8'hF8,  16,   8},
    '{8'hF0, 8'hE0,  16,  16},
    '{8'hF0, 8'hF0,  16,   0},
    '{8'hF0, 8'hFF,  16,  15},
    '{8'hFE, 8'hFF,   2,   1},
    '{8'hFF, 8'h00,   1,   1},
    '{8'h80, 8'hC0, 128,  64}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmr_en = 1'b0;
  logic pwm_en = 1'b0;
  logic [W-1:0] reload_val = '0;
  logic [W-1:0] duty_val = '0;
  logic pwm_out, cycle_end;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_ar_gen #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .pwm_en(pwm_en),
    .reload_val(reload_val), .duty_val(duty_val),
    .pwm_out(pwm_out), .cycle_end(cycle_end)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measure one full cycle between cycle_end strobes; if aligned, the
  // current negedge already sits in a strobe cycle.
  task automatic measure(input bit aligned, output int p, output int h);
    int g = 0;
    if (!aligned) begin
      do begin @(negedge clk); g++; end while (!cycle_end && g < 600);
    end
    p = 0; h = 0;
    do begin
      h += int'(pwm_out); p++;
      @(negedge clk);
    end while (!cycle_end && p < 600);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p, h, ce;
    repeat (4) @(negedge clk);
    check("R1 pwm_out in reset", int'(pwm_out), 0);
    check("R1 cycle_end in reset", int'(cycle_end), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    check("R1 cycle_end after reset", int'(cycle_end), 0);

    // R2: start goes high on the first clock
    reload_val = 8'hF0; duty_val = 8'hF8; pwm_en = 1'b1; tmr_en = 1'b1;
    @(negedge clk);
    check("R2 high after start", int'(pwm_out), 1);
    check("R2 no strobe at start", int'(cycle_end), 0);

    // Table: R3 period, R4/R5 high time, R6 strobe width
    for (int i = 0; i < NV; i++) begin
      tmr_en = 1'b0;
      @(negedge clk);
      reload_val = W'(VEC[i][0]); duty_val = W'(VEC[i][1]); tmr_en = 1'b1;
      measure(1'b0, p, h);
      check($sformatf("R3 period vec%0d", i), p, VEC[i][2]);
      check($sformatf("%s high vec%0d", (VEC[i][1] < VEC[i][0]) ? "R5" : "R4", i),
            h, VEC[i][3]);
      if (VEC[i][2] > 1) begin
        @(negedge clk);
        check($sformatf("R6 strobe width vec%0d", i), int'(cycle_end), 0);
      end
    end

    // R7: output gated off while counting continues
    tmr_en = 1'b0;
    @(negedge clk);
    reload_val = 8'hF0; duty_val = 8'hF8; pwm_en = 1'b0; tmr_en = 1'b1;
    measure(1'b0, p, h);
    check("R7 high with output disabled", h, 0);
    check("R7 period continues", p, 16);

    // R9/R10: mid-cycle rewrites apply at the next wrap
    pwm_en = 1'b1;
    measure(1'b0, p, h);
    reload_val = 8'hE0; duty_val = 8'hFC;
    measure(1'b1, p, h);
    check("R9 current period kept", p, 16);
    check("R10 current high kept", h, 8);
    measure(1'b1, p, h);
    check("R9 new period next cycle", p, 32);
    check("R10 new high next cycle", h, 28);

    // R8: timer disabled
    tmr_en = 1'b0;
    @(negedge clk);
    check("R8 pwm_out off", int'(pwm_out), 0);
    ce = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      ce += int'(cycle_end) + int'(pwm_out);
    end
    check("R8 no strobe or high while stopped", ce, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule